// File: doc/BRIEF.md
# Serial audio frame receiver

This block takes 16-bit PCM audio from a three-wire serial link: a bit clock, a frame clock and a data line. It runs entirely on the bit clock. It deserialises one mono sample per frame and presents it with a one-cycle valid strobe. A format input selects one of three framings:

- a stereo format with the MSB one bit late;
- a stereo format with the MSB aligned to the frame-clock edge;
- a multi-slot format whose frame clock is a short sync pulse.

In the two stereo formats a channel-select input picks the left word, the right word, or the signed average of both. In the multi-slot format the same input picks the first or the second 16-bit slot.

The block also measures every frame. Any frame that is not 32, 48 or 64 bit clocks long raises a framing-error flag. That flag stays up until a well-formed frame has been seen. Crossing into a system clock domain and all downstream audio processing are outside this block.

Top module: `audio_frame_rx`

## Requirements
- R1: While reset is asserted, and on leaving it, `sample` is 0, `smp_vld` is 0 and `frm_err` is 0.
- R2: Data on `ser_din` is sampled on the rising edge of `bit_clk`, 16 bits per word, most significant bit first.
- R3: With `fmt`=0 (delayed stereo), a low `frm_clk` marks the left half and a high `frm_clk` marks the right half. A frame begins at the cycle in which `frm_clk` is first sampled low. The MSB of each half arrives one bit clock after the cycle in which the new level is first sampled.
- R4: With `fmt`=1 (aligned stereo), a high `frm_clk` marks the left half and a low `frm_clk` marks the right half. A frame begins at the cycle in which `frm_clk` is first sampled high. The MSB arrives in that same cycle.
- R5: With `fmt`=2 or 3 (slot mode), a frame begins at the cycle in which `frm_clk` is first sampled high. Slot k occupies the 16 bits starting 1+16k cycles after that cycle. `chsel[0]`=0 picks slot 0 and `chsel[0]`=1 picks slot 1.
- R6: In the stereo formats, `chsel`=0 outputs the left word and `chsel`=1 outputs the right word. `chsel`=2 or 3 outputs (left+right)>>>1: the sum is formed in 17 bits and shifted arithmetically, so it never overflows.
- R7: Bits past the 16th of each stereo half, and all slots other than the selected one, have no effect on `sample`.
- R8: `smp_vld` is high for exactly one cycle per frame, in the cycle after the chosen word's LSB is sampled (after the right LSB when averaging). `sample` changes only together with `smp_vld`.
- R9: At each frame start after the first, the previous frame's length is checked. A length other than 32, 48 or 64 bit clocks sets `frm_err` one cycle later. A frame that reaches 65 bit clocks with no new frame start also sets `frm_err`.
- R10: At a frame start whose previous frame was 32, 48 or 64 bit clocks long, `frm_err` clears one cycle later.
- R11: Before the first frame start after reset, no word is captured and `smp_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low reset |
| frm_clk | input | 1 | Frame clock: half-frame level in the stereo formats, sync pulse in slot mode |
| ser_din | input | 1 | Serial data, MSB first |
| fmt | input | 2 | 0 delayed stereo, 1 aligned stereo, 2 or 3 slot mode |
| chsel | input | 2 | Stereo: 0 left, 1 right, 2/3 average; slot mode: bit 0 selects slot |
| sample | output | 16 | Last delivered signed sample |
| smp_vld | output | 1 | One-cycle strobe when `sample` is updated |
| frm_err | output | 1 | Framing error, held until a well-formed frame |

## Verification
The hardest case to reach is the 32-clock delayed-stereo frame. There, the right word's LSB falls on the very cycle in which the next frame starts, so the capture must still credit that bit to the old half. The bench reaches this case by generating a continuous per-cycle stream with the one-bit lag applied across frame boundaries, followed by a trailing frame-start cycle. The same trailing cycle is what closes the last frame for the length check, and so reveals set and cleared error flags. It also lets a deliberately short (40) or long (80) slot-mode frame be followed by a legal one.

// File: rtl/audio_frame_rx.sv
module audio_frame_rx #(
  parameter int W = 16
) (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic         frm_clk,
  input  logic         ser_din,
  input  logic [1:0]   fmt,
  input  logic [1:0]   chsel,
  output logic [W-1:0] sample,
  output logic         smp_vld,
  output logic         frm_err
);
  localparam int CW = $clog2(4*W) + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] WLEN = CW'(W);
  localparam logic [CW-1:0] LEN2 = CW'(2*W);
  localparam logic [CW-1:0] LEN3 = CW'(3*W);
  localparam logic [CW-1:0] LEN4 = CW'(4*W);

  logic          fclk_q, seen_q;
  logic [CW-1:0] idx_q, flen_q;
  logic [W-1:0]  sh_q, left_q;

  logic tdm, lj, lag;
  assign tdm = fmt[1];
  assign lj  = (fmt == 2'd1);
  assign lag = !lj;

  logic rise, fall, half_start, frame_start;
  assign rise        = frm_clk & ~fclk_q;
  assign fall        = ~frm_clk & fclk_q;
  assign half_start  = tdm ? rise : (rise | fall);
  assign frame_start = (tdm | lj) ? rise : fall;

  logic [CW-1:0] idx_n, pos, lo;
  assign idx_n = half_start ? '0 : ((idx_q == CMAX) ? idx_q : idx_q + 1'b1);
  // lagged formats: this cycle's bit belongs to the previous cycle's slot
  assign pos   = lag ? idx_q : idx_n;

  logic lvl, on_left;
  assign lvl     = lag ? fclk_q : frm_clk;
  assign on_left = lj ? lvl : ~lvl;

  assign lo = (tdm && chsel[0]) ? WLEN : '0;

  logic seen, take, done, emit;
  assign seen = seen_q | (frame_start & ~lag);
  assign take = seen && (pos >= lo) && (pos < lo + WLEN);
  assign done = take && (pos == lo + WLEN - 1'b1);
  assign emit = done && (tdm || ((chsel == 2'd0) ? on_left : !on_left));

  logic [W-1:0] word, avg, value;
  logic [W:0]   sum;
  assign word  = {sh_q[W-2:0], ser_din};
  assign sum   = {left_q[W-1], left_q} + {word[W-1], word};
  assign avg   = sum[W:1];
  assign value = (!tdm && chsel[1]) ? avg : word;

  logic legal, overrun;
  assign legal   = (flen_q == LEN2) || (flen_q == LEN3) || (flen_q == LEN4);
  assign overrun = seen_q && !frame_start && (flen_q == LEN4);

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q  <= 1'b0;
      seen_q  <= 1'b0;
      idx_q   <= CMAX;
      flen_q  <= '0;
      sh_q    <= '0;
      left_q  <= '0;
      sample  <= '0;
      smp_vld <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      fclk_q  <= frm_clk;
      idx_q   <= idx_n;
      smp_vld <= emit;
      if (frame_start) seen_q <= 1'b1;
      flen_q <= frame_start ? CW'(1) : ((flen_q == CMAX) ? flen_q : flen_q + 1'b1);
      if (take) sh_q <= word;
      if (done && !tdm && on_left) left_q <= word;
      if (emit) sample <= value;
      if (frame_start && seen_q) frm_err <= !legal;
      else if (overrun)          frm_err <= 1'b1;
    end
  end

  p_err_set_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (seen_q && frame_start && !legal) |=> frm_err);
  p_overrun_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    overrun |=> frm_err);
  p_err_clear_r10: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (seen_q && frame_start && legal) |=> !frm_err);
  p_vld_pulse_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    smp_vld |=> !smp_vld);
  p_sample_hold_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $changed(sample) |-> smp_vld);
  p_quiet_r11: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!seen_q && !frame_start) |=> !smp_vld);
endmodule

// File: tb/sim_audio_frame_rx.sv
module sim_audio_frame_rx;
  logic bit_clk = 1'b0, rst_n = 1'b0, frm_clk = 1'b0, ser_din = 1'b0;
  logic [1:0] fmt = 2'd0, chsel = 2'd0;
  logic [15:0] sample;
  logic smp_vld, frm_err;

  audio_frame_rx #(.W(16)) u0 (.bit_clk(bit_clk), .rst_n(rst_n), .frm_clk(frm_clk),
    .ser_din(ser_din), .fmt(fmt), .chsel(chsel), .sample(sample),
    .smp_vld(smp_vld), .frm_err(frm_err));

  always #2.5 bit_clk = ~bit_clk;

  int checks = 0, failures = 0;
  logic fc [0:1023];
  logic dt [0:1023];
  int len;
  int npulse, first_idx, wide;
  logic [15:0] last_smp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stream(input int fm);
    for (int i = 0; i < 1024; i++) begin fc[i] = 1'b0; dt[i] = 1'b0; end
    for (int i = 0; i < 3; i++) fc[i] = (fm == 0);
    len = 3;
  endtask

  task automatic put(input int p, input logic [15:0] w);
    for (int b = 0; b < 16; b++) dt[p+b] = w[15-b];
  endtask

  task automatic add_frames(input int fm, input int n, input int cnt,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] c, input logic [15:0] d);
    for (int f = 0; f < cnt; f++) begin
      int s = len;
      int h = n / 2;
      for (int i = 0; i < n; i++)
        fc[s+i] = (fm >= 2) ? (i == 0) : ((fm == 0) ? (i >= h) : (i < h));
      if (fm >= 2) begin
        put(s+1, a); put(s+17, b);
        if (n >= 48) put(s+33, c);
        if (n >= 64) put(s+49, d);
      end else begin
        int lg = (fm == 0);
        put(s+lg, a); put(s+lg+h, b);
        for (int k = 16; k < h; k++) begin
          dt[s+lg+k] = 1'b1;
          dt[s+lg+h+k] = k[0];
        end
      end
      len += n;
    end
  endtask

  task automatic add_tail(input int fm);
    fc[len] = (fm >= 2) ? 1'b1 : ((fm == 0) ? 1'b0 : 1'b1);
    len++;
  endtask

  task automatic sample_out(input int idx);
    if (smp_vld) begin
      if (npulse > 0 && first_idx >= 0 && wide == idx - 1) wide = -100;
      if (first_idx < 0) first_idx = idx;
      npulse++;
      last_smp = sample;
      if (wide != -100) wide = idx;
    end
  endtask

  task automatic run(input int fm, input logic [1:0] cs);
    logic hold;
    hold = (fm >= 2) ? 1'b0 : fc[len-1];
    @(negedge bit_clk);
    rst_n = 1'b0; fmt = 2'(fm); chsel = cs; frm_clk = fc[0]; ser_din = 1'b0;
    repeat (2) @(negedge bit_clk);
    rst_n = 1'b1;
    npulse = 0; first_idx = -1; wide = -1; last_smp = 16'h0;
    for (int t = 0; t < len + 3; t++) begin
      if (t > 0) @(negedge bit_clk);
      sample_out(t - 1);
      frm_clk = (t < len) ? fc[t] : hold;
      ser_din = (t < len) ? dt[t] : 1'b0;
    end
    @(negedge bit_clk);
    sample_out(len + 2);
  endtask

  task automatic t_reset;
    @(negedge bit_clk); rst_n = 1'b0;
    @(negedge bit_clk);
    chk(sample == 16'h0, "R1 sample in reset", sample, 0);
    chk(smp_vld == 1'b0, "R1 vld in reset", smp_vld, 0);
    chk(frm_err == 1'b0, "R1 err in reset", frm_err, 0);
    clear_stream(0);
    for (int i = 0; i < 40; i++) begin fc[i] = 1'b1; dt[i] = 1'b1; end
    len = 40;
    run(0, 2'd1);
    chk(npulse == 0, "R11 no output before frame start", npulse, 0);
    chk(frm_err == 1'b0, "R1 err after reset", frm_err, 0);
  endtask

  task automatic t_stereo(input string tag, input int fm, input logic [1:0] cs, input int n,
      input int cnt, input logic [15:0] a, input logic [15:0] b, input logic [15:0] exp,
      input int exp_first);
    clear_stream(fm);
    add_frames(fm, n, cnt, a, b, 16'h0, 16'h0);
    add_tail(fm);
    run(fm, cs);
    chk(last_smp == exp, {tag, " sample (R2 R6 R7)"}, last_smp, exp);
    chk(npulse == cnt, {tag, " one strobe per frame R8"}, npulse, cnt);
    chk(wide != -100, {tag, " strobe width R8"}, 0, 0);
    chk(frm_err == 1'b0, {tag, " no error on legal frames R10"}, frm_err, 0);
    if (exp_first >= 0)
      chk(first_idx == exp_first, {tag, " strobe timing"}, first_idx, exp_first);
  endtask

  task automatic t_slot(input string tag, input logic [1:0] cs, input int n,
      input logic [15:0] exp, input int exp_first);
    clear_stream(2);
    add_frames(2, n, 2, 16'hA5A5, 16'h7E7E, 16'h1111, 16'h2222);
    add_tail(2);
    run(2, cs);
    chk(last_smp == exp, {tag, " R5 slot select R7"}, last_smp, exp);
    chk(npulse == 2, {tag, " R8 strobes"}, npulse, 2);
    chk(frm_err == 1'b0, {tag, " R10 legal"}, frm_err, 0);
    if (exp_first >= 0)
      chk(first_idx == exp_first, {tag, " R5 strobe timing"}, first_idx, exp_first);
  endtask

  task automatic t_errors;
    clear_stream(2);
    add_frames(2, 64, 1, 16'h1, 16'h2, 16'h3, 16'h4);
    add_frames(2, 40, 1, 16'h1, 16'h2, 16'h3, 16'h4);
    add_tail(2);
    run(2, 2'd0);
    chk(frm_err == 1'b1, "R9 short slot frame flagged", frm_err, 1);

    clear_stream(2);
    add_frames(2, 64, 1, 16'h1, 16'h2, 16'h3, 16'h4);
    add_frames(2, 40, 1, 16'h1, 16'h2, 16'h3, 16'h4);
    add_frames(2, 32, 1, 16'h1, 16'h2, 16'h3, 16'h4);
    add_tail(2);
    run(2, 2'd0);
    chk(frm_err == 1'b0, "R10 error cleared by good frame", frm_err, 0);

    clear_stream(2);
    add_frames(2, 64, 1, 16'h1, 16'h2, 16'h3, 16'h4);
    add_frames(2, 80, 1, 16'h1, 16'h2, 16'h3, 16'h4);
    add_tail(2);
    run(2, 2'd0);
    chk(frm_err == 1'b1, "R9 long slot frame flagged", frm_err, 1);

    clear_stream(0);
    add_frames(0, 40, 2, 16'h1, 16'h2, 16'h0, 16'h0);
    add_tail(0);
    run(0, 2'd0);
    chk(frm_err == 1'b1, "R9 stereo 40-clock frame flagged", frm_err, 1);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        t_reset();
        t_stereo("R3 delayed left 64", 0, 2'd0, 64, 3, 16'h1234, 16'h8001, 16'h1234, 19);
        t_stereo("R3 delayed right 32", 0, 2'd1, 32, 3, 16'h0F0F, 16'hC3A5, 16'hC3A5, -1);
        t_stereo("R6 delayed avg 48", 0, 2'd2, 48, 2, 16'hFFFF, 16'hFFFE, 16'hFFFE, -1);
        t_stereo("R6 delayed avg odd 64", 0, 2'd3, 64, 2, 16'h0003, 16'hFFFC, 16'hFFFF, -1);
        t_stereo("R4 aligned left 64", 1, 2'd0, 64, 2, 16'h2468, 16'h1357, 16'h2468, 18);
        t_stereo("R4 aligned right 48", 1, 2'd1, 48, 2, 16'h2468, 16'h1357, 16'h1357, -1);
        t_stereo("R6 aligned avg max 32", 1, 2'd2, 32, 2, 16'h7FFF, 16'h7FFF, 16'h7FFF, -1);
        t_stereo("R6 aligned avg min 48", 1, 2'd3, 48, 2, 16'h8000, 16'h8000, 16'h8000, -1);
        t_slot("slot0 64", 2'd0, 64, 16'hA5A5, 19);
        t_slot("slot1 32", 2'd1, 32, 16'h7E7E, -1);
        t_slot("slot1 48", 2'd3, 48, 16'h7E7E, -1);
        t_slot("slot0 48", 2'd2, 48, 16'hA5A5, -1);
        t_errors();
      end
      begin
        while (wd < 150000) begin @(posedge bit_clk); wd++; end
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", wd);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule